// File: doc/BRIEF.md
# Prescaled Interval Timer

This block produces a periodic interrupt for a processor core. A programmable prescaler divides the core clock: its down-counter runs from a scale value to zero and then issues one step pulse. Each step lowers a 16-bit count by one. When a step finds the count already at zero, the block reloads the count from a period register in that same cycle and raises a one-cycle interrupt pulse. No idle cycle is inserted, so the spacing between interrupts is exactly (period+1)×(scale+1) core cycles.

Software uses a plain single-cycle register bus to program the block. A write is presented with `wr_en` high for one cycle. A read is combinational from `addr`. There is no data stream at this edge, so there is no valid/ready handshake and no back-pressure. A write is taken on the clock edge it is presented at. A level `enable` input freezes the whole timer while it is low.

Top module: `itmr_timer`

## Requirements
- R1: After reset, scale, period, count and prescaler residue all read 0, and `irq` is 0.
- R2: While `enable` is high, the prescaler residue drops by one each cycle. When the residue is 0, it reloads from scale and a step is issued, so one step occurs every scale+1 cycles. Scale 0 steps every cycle, and scale 255 steps every 256 cycles.
- R3: A step that finds the count nonzero lowers the count by exactly one.
- R4: A step that finds the count at 0 reloads the count from period at that edge, and `irq` is high in the following cycle. Interrupts therefore repeat every (period+1)×(scale+1) cycles, and period 0 interrupts on every step.
- R5: Suppose count is loaded with C and the residue with S (through a scale write of S) while disabled. After `enable` rises, the first `irq` is seen after exactly (C+1)×(S+1) enabled clock edges.
- R6: While `enable` is low, the residue and the count hold their values and no interrupt is raised. Counting resumes from the held state when `enable` returns high.
- R7: A write with `wr_en` high takes effect at the next clock edge. Address 0 writes scale (`wdata[7:0]`) and also loads the residue with that value. Address 1 writes period. Address 2 writes count. A count write wins over a step in the same cycle.
- R8: `rdata` shows scale zero-extended at address 0, period at address 1, count at address 2, and the live prescaler residue at address 3. A write to address 3 changes nothing.
- R9: When the interrupt spacing exceeds one cycle, `irq` is high for exactly one cycle per interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer runs while high, freezes while low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select: 0 scale, 1 period, 2 count, 3 residue |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps every pair of small scale and period values and measures the first latency and the repeat spacing. A design that lost a cycle on reload, or counted scale instead of scale+1, would be off by a fixed amount in every one of these checks. Period 0 and scale 0 are included on purpose: an off-by-one there would show up as a doubled interval or a stuck pulse. The bench freezes the timer mid-count and then resumes it, expecting an exact remaining latency, which catches a prescaler that slips while disabled. It also writes the count in a cycle where a step fires, which exposes a design in which the decrement beats the write. A write to the read-only residue address and the zero-extension of an oversized scale write are checked through readback.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    REG_SCALE  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_RESID  = 2'd3
  } itmr_reg_e;
endpackage

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int SCALE_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [CNT_W-1:0]   count,
  input  logic [SCALE_W-1:0] resid,
  output logic [SCALE_W-1:0] scale_q,
  output logic [CNT_W-1:0]   period_q,
  output logic               scale_wr,
  output logic               count_wr,
  output logic [CNT_W-1:0]   rdata
);
  itmr_reg_e sel;
  assign sel      = itmr_reg_e'(addr);
  assign scale_wr = wr_en && (sel == REG_SCALE);
  assign count_wr = wr_en && (sel == REG_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q  <= '0;
      period_q <= '0;
    end else begin
      if (scale_wr) scale_q <= wdata[SCALE_W-1:0];
      if (wr_en && (sel == REG_PERIOD)) period_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      REG_SCALE:  rdata = CNT_W'(scale_q);
      REG_PERIOD: rdata = period_q;
      REG_COUNT:  rdata = count;
      REG_RESID:  rdata = CNT_W'(resid);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               load,
  input  logic [SCALE_W-1:0] load_val,
  input  logic [SCALE_W-1:0] scale,
  output logic [SCALE_W-1:0] resid_q,
  output logic               step
);
  logic expired;
  assign expired = (resid_q == '0);
  assign step    = enable && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      resid_q <= '0;
    else if (load)   resid_q <= load_val;
    else if (enable) resid_q <= expired ? scale : resid_q - 1'b1;
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_q
);
  logic at_zero;
  assign at_zero = (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= step && at_zero;
      if (load)      count_q <= load_val;
      else if (step) count_q <= at_zero ? period : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/itmr_timer.sv
module itmr_timer #(
  parameter int SCALE_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W-1:0] resid_q;
  logic [CNT_W-1:0]   period_q;
  logic [CNT_W-1:0]   count_q;
  logic               scale_wr;
  logic               count_wr;
  logic               step;

  itmr_regfile #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count(count_q), .resid(resid_q), .scale_q(scale_q), .period_q(period_q),
    .scale_wr(scale_wr), .count_wr(count_wr), .rdata(rdata)
  );

  itmr_prescale #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(scale_wr),
    .load_val(wdata[SCALE_W-1:0]), .scale(scale_q), .resid_q(resid_q), .step(step)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(count_wr), .load_val(wdata),
    .period(period_q), .count_q(count_q), .irq_q(irq)
  );
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int SCALE_W = 8,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               wr_en,
  input logic [1:0]         addr,
  input logic [CNT_W-1:0]   wdata,
  input logic               irq,
  input logic [SCALE_W-1:0] scale,
  input logic [CNT_W-1:0]   period,
  input logic [CNT_W-1:0]   count,
  input logic [SCALE_W-1:0] resid
);
  AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && resid == '0 && !wr_en) |=> resid == $past(scale)); // R2
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && resid == '0 && count != '0 && !wr_en) |=> count == $past(count) - 1'b1); // R3
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && resid == '0 && count == '0 && !wr_en) |=> count == $past(period)); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(enable && resid == '0 && count == '0)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en) |=> ($stable(count) && $stable(resid) && !irq)); // R6
  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> count == $past(wdata)); // R7
  AST_RESID_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !enable) |=> ($stable(scale) && $stable(period) && $stable(resid))); // R8
endmodule

bind itmr_timer itmr_chk #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .scale(scale_q), .period(period_q),
  .count(count_q), .resid(resid_q)
);

// File: tb/sim_itmr_timer.sv
module sim_itmr_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  itmr_timer u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, v2, n;
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 reset register value", v, 0);
    end
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

    // R2 R3 R4 R5 R9 sweep
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        int iv;
        iv = (p + 1) * (s + 1);
        enable = 1'b0;
        wr(2'd0, 16'(s)); wr(2'd1, 16'(p)); wr(2'd2, 16'(p));
        enable = 1'b1;
        wait_irq(n);
        check(n == iv, "R5 first latency", n, iv);
        for (int k = 0; k < 2; k++) begin
          n = 0;
          do begin
            @(negedge clk); n++;
            if (n == 1 && iv > 1) check(irq == 1'b0, "R9 one-cycle pulse", int'(irq), 0);
          end while (!irq && n < 5000);
          check(n == iv, "R4 repeat interval", n, iv);
        end
      end
    end

    // R2 largest scale
    enable = 1'b0;
    wr(2'd0, 16'd255); wr(2'd1, 16'd1); wr(2'd2, 16'd1);
    enable = 1'b1;
    wait_irq(n);
    check(n == 512, "R2 scale 255 latency", n, 512);
    wait_irq(n);
    check(n == 512, "R2 scale 255 interval", n, 512);

    // R6 freeze mid-count
    enable = 1'b0;
    wr(2'd0, 16'd9); wr(2'd1, 16'd50); wr(2'd2, 16'd50);
    enable = 1'b1;
    repeat (7) @(negedge clk);
    enable = 1'b0;
    rd(2'd3, v);
    check(v == 2, "R6 residue before freeze", v, 2);
    repeat (10) begin
      @(negedge clk);
      if (irq) check(1'b0, "R6 irq while frozen", 1, 0);
    end
    rd(2'd3, v2);
    check(v2 == v, "R6 residue held", v2, v);
    rd(2'd2, v2);
    check(v2 == 50, "R6 count held", v2, 50);
    enable = 1'b1;
    wait_irq(n);
    check(n == 503, "R6 resumed latency", n, 503);

    // R7 count write beats step
    enable = 1'b0;
    wr(2'd0, 16'd0); wr(2'd1, 16'd1000);
    enable = 1'b1;
    wr(2'd2, 16'h0100);
    rd(2'd2, v);
    check(v == 16'h0100, "R7 count write wins", v, 16'h0100);
    @(negedge clk);
    rd(2'd2, v);
    check(v == 16'h00FF, "R3 decrement after write", v, 16'h00FF);

    // R7 R8 scale width and read-only residue
    enable = 1'b0;
    wr(2'd0, 16'hFFAB);
    rd(2'd0, v);
    check(v == 16'h00AB, "R8 scale zero-extended", v, 16'h00AB);
    rd(2'd3, v);
    check(v == 16'h00AB, "R7 scale write loads residue", v, 16'h00AB);
    wr(2'd3, 16'h0012);
    rd(2'd3, v);
    check(v == 16'h00AB, "R8 residue write ignored", v, 16'h00AB);
    rd(2'd0, v);
    check(v == 16'h00AB, "R8 scale unchanged by addr 3", v, 16'h00AB);
    rd(2'd1, v);
    check(v == 1000, "R8 period readback", v, 1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule